// File: doc/BRIEF.md
# Card Host Event and Interrupt Status Unit

This unit gathers single-cycle event pulses from the command, data-transfer and card-detect logic of a memory-card host. It holds them in two byte-wide sticky status registers and qualifies them with two byte-wide enable registers. It drives one level-sensitive interrupt line. Software reaches the unit through a small byte register port. Status bits are cleared by writing ones, so a handler can write back the value it read and lose no event that arrived in the meantime.

The unit also shows three live pad levels: write protect and two card-detect sources. These pass through a synchronizer, and an edge on a detect input is turned into sticky flags. A configuration byte holds the global interrupt gate, the choice of detect source, a polarity option for card presence, and the card power-off control with its own polarity option.

Register map (3-bit address): 0 = status A, 1 = status B, 2 = enable A, 3 = enable B, 4 = configuration; other addresses read zero. Configuration bits: 0 interrupt gate, 1 detect from pin source, 2 detect from DATA3 source, 3 presence invert, 4 power invert, 5 power-off request; bits 7:6 read zero.

Top module: `sdh_irq_unit`

## Requirements
- R1: After reset every register reads 0x00, `irq_o` is low, `card_power_o` is high and `card_present_o` is high (with all pad inputs at 0).
- R2: A pulse on `evt_st1_i[n]` sets status B bit n on the next clock edge. A pulse on `evt_blk_i[0]` sets status A bit 4 (multi-block done) and a pulse on `evt_blk_i[1]` sets status A bit 5 (block done). Set bits stay set until cleared.
- R3: Writing a byte to a status register clears exactly the sticky bits that are 1 in that byte. Bits written 0 keep their value.
- R4: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: Status A bit 1 shows `wp_in`, bit 2 shows `cd_dat3_in` and bit 3 shows `cd_gpi_in`, each delayed by two clocks. Writes do not change them, and status A bit 0 always reads 0.
- R6: Only enable A bits 7:4, enable B bits 7:1 and configuration bits 5:0 are stored. All other bits of those registers read 0.
- R7: `irq_o` is high exactly when configuration bit 0 is 1 and some status bit is 1 while its enable bit is also 1. Status B bit 0 (SDIO event) never raises `irq_o`.
- R8: Any edge on either synchronized detect level sets status A bit 6. An edge on a detect level whose source is selected (configuration bit 1 for the pin, bit 2 for DATA3) also sets status A bit 7.
- R9: `card_present_o` is the inverse of (synchronized `cd_gpi_in` XOR configuration bit 3).
- R10: `card_power_o` is high when configuration bit 5 equals configuration bit 4, so with the invert option set, writing 1 turns power on.
- R11: `irq_o` falls only in the cycle after a register write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register (combinational) |
| evt_st1_i | input | 8 | Event pulses for status B bits 7:0 |
| evt_blk_i | input | 2 | Event pulses: bit 0 multi-block done, bit 1 block done |
| wp_in | input | 1 | Asynchronous write-protect level |
| cd_dat3_in | input | 1 | Asynchronous card-detect level from DATA3 |
| cd_gpi_in | input | 1 | Asynchronous card-detect level from the detect pin |
| irq_o | output | 1 | Level interrupt |
| card_present_o | output | 1 | Card present indication |
| card_power_o | output | 1 | Card power enable |

## Verification
The bench builds the unit with the default two-stage synchronizer. This makes the live-bit delay exact, so the bench checks the cycle a pad level appears as well as the settled value. The same depth fixes the three-edge delay from a pad edge to the sticky detect flags, so the bench can observe a selected and an unselected source within a few cycles. A table of pulse, enable and clear patterns exercises how sticky bits accumulate and how the interrupt is qualified. Directed steps cover the same-cycle set and clear, and the polarity options.

// File: rtl/sdh_irq_pkg.sv
package sdh_irq_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_STAT0 = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT1 = 3'd1;
  localparam logic [ADDR_W-1:0] A_MASK0 = 3'd2;
  localparam logic [ADDR_W-1:0] A_MASK1 = 3'd3;
  localparam logic [ADDR_W-1:0] A_CFG   = 3'd4;

  // configuration byte fields
  localparam int CF_GATE    = 0;
  localparam int CF_SEL_PIN = 1;
  localparam int CF_SEL_D3  = 2;
  localparam int CF_CD_INV  = 3;
  localparam int CF_PW_INV  = 4;
  localparam int CF_PW_OFF  = 5;

  // status A positions
  localparam int S0_WP    = 1;
  localparam int S0_D3    = 2;
  localparam int S0_PIN   = 3;
  localparam int S0_MBLK  = 4;
  localparam int S0_BLK   = 5;
  localparam int S0_CHG   = 6;
  localparam int S0_INS   = 7;

  localparam logic [DATA_W-1:0] STICKY0 = 8'hF0;
  localparam logic [DATA_W-1:0] STICKY1 = 8'hFF;
  localparam logic [DATA_W-1:0] EN0_IMPL = 8'hF0;
  localparam logic [DATA_W-1:0] EN1_IMPL = 8'hFE;
  localparam logic [DATA_W-1:0] CFG_IMPL = 8'h3F;

  // next sticky value: clear by ones, set wins
  function automatic logic [DATA_W-1:0] w1c_next(
    input logic [DATA_W-1:0] cur, input logic [DATA_W-1:0] set,
    input logic [DATA_W-1:0] clr);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic any_pending(
    input logic [DATA_W-1:0] s0, input logic [DATA_W-1:0] e0,
    input logic [DATA_W-1:0] s1, input logic [DATA_W-1:0] e1);
    return |((s0 & e0 & EN0_IMPL) | (s1 & e1 & EN1_IMPL));
  endfunction

  function automatic logic present_of(input logic pin_lvl, input logic inv);
    return ~(pin_lvl ^ inv);
  endfunction

  function automatic logic power_of(input logic off_bit, input logic inv);
    return ~(off_bit ^ inv);
  endfunction
endpackage

// File: rtl/sdh_sync.sv
module sdh_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] sr;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= '0;
      else        sr <= {sr[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = sr[STAGES-1];
  end

  if (STAGES == 2) begin : g_chk
    assert_sync_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(rst_n, 2)) |-> (q_o == $past(d_i, 2)));
  end
endmodule

// File: rtl/sdh_w1c_bank.sv
module sdh_w1c_bank
  import sdh_irq_pkg::*;
#(
  parameter logic [DATA_W-1:0] KEEP = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] set_i,
  input  logic [DATA_W-1:0] clr_i,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= w1c_next(q, set_i & KEEP, clr_i) & KEEP;
  end
  assign q_o = q;

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_i & KEEP)) |=> ((q & $past(set_i & KEEP)) == $past(set_i & KEEP)));
  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_i) |=> ((q & $past(clr_i) & ~$past(set_i)) == '0));
  assert_no_self_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i == '0) |=> ((q & ~$past(q)) == '0));
endmodule

// File: rtl/sdh_cd_edge.sv
module sdh_cd_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_lvl_i,
  input  logic d3_lvl_i,
  input  logic sel_pin_i,
  input  logic sel_d3_i,
  output logic chg_o,
  output logic ins_o
);
  logic pin_prev, d3_prev;
  logic pin_edge, d3_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_prev <= 1'b0;
      d3_prev  <= 1'b0;
    end else begin
      pin_prev <= pin_lvl_i;
      d3_prev  <= d3_lvl_i;
    end
  end

  assign pin_edge = pin_lvl_i ^ pin_prev;
  assign d3_edge  = d3_lvl_i ^ d3_prev;
  assign chg_o    = pin_edge | d3_edge;
  assign ins_o    = (pin_edge & sel_pin_i) | (d3_edge & sel_d3_i);
endmodule

// File: rtl/sdh_irq_unit.sv
module sdh_irq_unit
  import sdh_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [DATA_W-1:0] evt_st1_i,
  input  logic [1:0]        evt_blk_i,
  input  logic              wp_in,
  input  logic              cd_dat3_in,
  input  logic              cd_gpi_in,
  output logic              irq_o,
  output logic              card_present_o,
  output logic              card_power_o
);
  localparam int PADS = 3;

  logic [PADS-1:0]   pad_s;
  logic              wp_s, d3_s, pin_s;
  logic              cd_chg, cd_ins;
  logic [DATA_W-1:0] en0_q, en1_q, cfg_q;
  logic [DATA_W-1:0] st0_q, st1_q;
  logic [DATA_W-1:0] st0_set, st0_clr, st1_clr;
  logic [DATA_W-1:0] live0;
  logic              wr_st0, wr_st1;

  sdh_sync #(.WIDTH(PADS), .STAGES(SYNC_STAGES)) i_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  ({cd_gpi_in, cd_dat3_in, wp_in}),
    .q_o  (pad_s)
  );
  assign wp_s  = pad_s[0];
  assign d3_s  = pad_s[1];
  assign pin_s = pad_s[2];

  sdh_cd_edge i_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_lvl_i(pin_s),
    .d3_lvl_i (d3_s),
    .sel_pin_i(cfg_q[CF_SEL_PIN]),
    .sel_d3_i (cfg_q[CF_SEL_D3]),
    .chg_o    (cd_chg),
    .ins_o    (cd_ins)
  );

  assign wr_st0  = reg_wr && (reg_addr == A_STAT0);
  assign wr_st1  = reg_wr && (reg_addr == A_STAT1);
  assign st0_clr = wr_st0 ? reg_wdata : '0;
  assign st1_clr = wr_st1 ? reg_wdata : '0;

  always_comb begin
    st0_set          = '0;
    st0_set[S0_MBLK] = evt_blk_i[0];
    st0_set[S0_BLK]  = evt_blk_i[1];
    st0_set[S0_CHG]  = cd_chg;
    st0_set[S0_INS]  = cd_ins;
  end

  sdh_w1c_bank #(.KEEP(STICKY0)) i_st0 (
    .clk(clk), .rst_n(rst_n), .set_i(st0_set), .clr_i(st0_clr), .q_o(st0_q)
  );
  sdh_w1c_bank #(.KEEP(STICKY1)) i_st1 (
    .clk(clk), .rst_n(rst_n), .set_i(evt_st1_i), .clr_i(st1_clr), .q_o(st1_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en0_q <= '0;
      en1_q <= '0;
      cfg_q <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_MASK0: en0_q <= reg_wdata & EN0_IMPL;
        A_MASK1: en1_q <= reg_wdata & EN1_IMPL;
        A_CFG:   cfg_q <= reg_wdata & CFG_IMPL;
        default: ;
      endcase
    end
  end

  always_comb begin
    live0         = '0;
    live0[S0_WP]  = wp_s;
    live0[S0_D3]  = d3_s;
    live0[S0_PIN] = pin_s;
  end

  always_comb begin
    case (reg_addr)
      A_STAT0: reg_rdata = st0_q | live0;
      A_STAT1: reg_rdata = st1_q;
      A_MASK0: reg_rdata = en0_q;
      A_MASK1: reg_rdata = en1_q;
      A_CFG:   reg_rdata = cfg_q;
      default: reg_rdata = '0;
    endcase
  end

  assign irq_o          = cfg_q[CF_GATE] & any_pending(st0_q, en0_q, st1_q, en1_q);
  assign card_present_o = present_of(pin_s, cfg_q[CF_CD_INV]);
  assign card_power_o   = power_of(cfg_q[CF_PW_OFF], cfg_q[CF_PW_INV]);

  assert_irq_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> $past(reg_wr));
  assert_insert_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cd_ins |=> st0_q[S0_INS]);
  assert_sdio_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ((st1_q & ~8'h01) != '0 || st0_q != '0));
endmodule

// File: tb/test_sdh_irq_unit.sv
module test_sdh_irq_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [7:0] evt_st1_i = '0;
  logic [1:0] evt_blk_i = '0;
  logic       wp_in = 1'b0, cd_dat3_in = 1'b0, cd_gpi_in = 1'b0;
  logic       irq_o, card_present_o, card_power_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sdh_irq_unit i_sdh_irq_unit (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_st1_i(evt_st1_i),
    .evt_blk_i(evt_blk_i), .wp_in(wp_in), .cd_dat3_in(cd_dat3_in),
    .cd_gpi_in(cd_gpi_in), .irq_o(irq_o), .card_present_o(card_present_o),
    .card_power_o(card_power_o)
  );

  // fields: pulse, enable B, clear, status after pulse, status after clear, irq
  localparam logic [40:0] VECS [6] = '{
    {8'h02, 8'h02, 8'h02, 8'h02, 8'h00, 1'b1},
    {8'h01, 8'hFF, 8'h00, 8'h01, 8'h01, 1'b0},
    {8'h84, 8'h80, 8'h01, 8'h85, 8'h84, 1'b1},
    {8'h30, 8'h40, 8'h80, 8'hB4, 8'h34, 1'b0},
    {8'h48, 8'h08, 8'hFF, 8'h7C, 8'h00, 1'b1},
    {8'h00, 8'hFF, 8'h00, 8'h00, 8'h00, 1'b0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [7:0] e1, input logic [1:0] eb);
    @(negedge clk);
    evt_st1_i = e1; evt_blk_i = eb;
    @(negedge clk);
    evt_st1_i = '0; evt_blk_i = '0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    wait_cyc(3);
    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], v);
      chk("R1 register reset", v, 8'h00);
    end
    chk("R1 irq reset", {7'd0, irq_o}, 8'h00);
    chk("R1 power reset", {7'd0, card_power_o}, 8'h01);
    chk("R1 present reset", {7'd0, card_present_o}, 8'h01);
    @(negedge clk); rst_n = 1'b1;
    wait_cyc(2);

    // table walk: R2 R3 R7
    wr(3'd4, 8'h01);
    for (int i = 0; i < 6; i++) begin
      wr(3'd3, VECS[i][32:25]);
      pulse(VECS[i][40:33], 2'b00);
      rd(3'd1, v);
      chk("R2 sticky accumulate", v, VECS[i][16:9]);
      chk("R7 irq qualify", {7'd0, irq_o}, {7'd0, VECS[i][0]});
      wr(3'd1, VECS[i][24:17]);
      rd(3'd1, v);
      chk("R3 write-one clear", v, VECS[i][8:1]);
    end

    // R6 implemented bits
    wr(3'd2, 8'hFF); rd(3'd2, v); chk("R6 enable A bits", v, 8'hF0);
    wr(3'd3, 8'hFF); rd(3'd3, v); chk("R6 enable B bits", v, 8'hFE);
    wr(3'd4, 8'hFF); rd(3'd4, v); chk("R6 config bits", v, 8'h3F);

    // status A events and gate
    wr(3'd4, 8'h01); wr(3'd3, 8'h00); wr(3'd0, 8'hFF);
    pulse(8'h00, 2'b01);
    rd(3'd0, v); chk("R2 multi-block flag", v, 8'h10);
    chk("R7 irq from status A", {7'd0, irq_o}, 8'h01);
    wait_cyc(3);
    chk("R11 irq held without write", {7'd0, irq_o}, 8'h01);
    wr(3'd4, 8'h00);
    chk("R7 gate closed", {7'd0, irq_o}, 8'h00);
    wr(3'd4, 8'h01);

    // R4 same-cycle set and clear
    @(negedge clk);
    evt_blk_i = 2'b10; reg_addr = 3'd0; reg_wdata = 8'h30; reg_wr = 1'b1;
    @(negedge clk);
    evt_blk_i = 2'b00; reg_wr = 1'b0;
    rd(3'd0, v); chk("R4 set wins over clear", v, 8'h20);

    // R5 live bits
    wr(3'd0, 8'hFF);
    @(negedge clk); wp_in = 1'b1;
    @(negedge clk);
    rd(3'd0, v); chk("R5 wp after one clock", v & 8'h02, 8'h00);
    @(negedge clk);
    rd(3'd0, v); chk("R5 wp after two clocks", v, 8'h02);
    wr(3'd0, 8'hFF);
    rd(3'd0, v); chk("R5 live bit ignores write", v, 8'h02);

    // R8 detect edges, R9 presence
    wr(3'd4, 8'h03);
    @(negedge clk); cd_gpi_in = 1'b1;
    wait_cyc(4);
    rd(3'd0, v); chk("R8 selected pin edge", v, 8'hCA);
    chk("R9 present with pin high", {7'd0, card_present_o}, 8'h00);
    wr(3'd0, 8'hFF);
    wr(3'd4, 8'h05);
    @(negedge clk); cd_gpi_in = 1'b0;
    wait_cyc(4);
    rd(3'd0, v); chk("R8 unselected pin edge", v & 8'hC0, 8'h40);
    chk("R9 present with pin low", {7'd0, card_present_o}, 8'h01);
    wr(3'd4, 8'h08);
    chk("R9 present inverted", {7'd0, card_present_o}, 8'h00);

    // R10 power polarity
    wr(3'd4, 8'h20); chk("R10 power off", {7'd0, card_power_o}, 8'h00);
    wr(3'd4, 8'h30); chk("R10 inverted on", {7'd0, card_power_o}, 8'h01);
    wr(3'd4, 8'h10); chk("R10 inverted off", {7'd0, card_power_o}, 8'h00);
    wr(3'd4, 8'h00); chk("R10 normal on", {7'd0, card_power_o}, 8'h01);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule